// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the integer execute stage of a 32-bit load/store processor core. It is purely combinational. Each cycle it receives the decoded fields of one instruction: the two register operands, the constant shift field, the primary opcode, the function code and the 16-bit immediate. From these it produces the value to be written back, a write-enable for the destination register, an overflow trap flag and a reserved-instruction flag.

The operations are register-register add, subtract, bitwise logic, shifts and set-on-less-than. The immediate forms cover add, compare, logic and load-upper. The opcode or function code fixes three things: which operation runs, whether the 16-bit constant is widened with its sign or with zeros, and whether a signed overflow raises a trap. When a trapping add or subtract overflows, the write-back is withheld. An encoding the unit does not know is reported as reserved and never writes.

The register file, multiply/divide, memory access, branch resolution and pipeline control are outside this block.

Top module: `risc_exec_unit`

## Requirements
- R1: With opcode 0x00, function codes 0x20 (trapping add), 0x21 (plain add), 0x22 (trapping subtract) and 0x23 (plain subtract) give rs+rt or rs-rt, wrapped modulo 2^32, on `result`, with `wr_en` high when no overflow trap occurs.
- R2: With opcode 0x00, function codes 0x24, 0x25, 0x26 and 0x27 give AND, OR, XOR and NOR of rs and rt. For rs=0xABCD1234 and rt=0xFFFF0000 the results are 0xABCD0000, 0xFFFF1234, 0x54321234 and 0x0000EDCB.
- R3: With opcode 0x00, function codes 0x00, 0x02 and 0x03 shift rt by the 5-bit `shamt` field: left logical, right logical and right arithmetic. Logical shifts bring in zeros; the arithmetic shift copies the sign bit of rt into the vacated bits.
- R4: With opcode 0x00, function codes 0x04, 0x06 and 0x07 perform the same three shifts of rt, but the amount comes from the low 5 bits of rs. The upper bits of rs are ignored.
- R5: Trapping add (funct 0x20), trapping subtract (funct 0x22) and trapping add-immediate (opcode 0x08) assert `ovf_trap` and hold `wr_en` low on signed overflow. For add, overflow means both operands have the same sign and the sum's sign differs from it. For subtract, overflow means the operand signs differ and the difference's sign differs from rs. In that case `result` still shows the wrapped value.
- R6: Plain add (funct 0x21), plain subtract (funct 0x23) and plain add-immediate (opcode 0x09) never assert `ovf_trap` and always assert `wr_en`.
- R7: With opcode 0x00, function code 0x2A writes 1 if rs < rt as signed values and 0 otherwise; function code 0x2B makes the same comparison unsigned. For rs=1 and rt=0xFFFFFFFF the signed form gives 0 and the unsigned form gives 1.
- R8: Opcodes 0x08, 0x09, 0x0A and 0x0B sign-extend the immediate to 32 bits and then add it (0x08, 0x09), compare it as signed (0x0A) or compare it as unsigned (0x0B) against rs. The immediate forms ignore rt.
- R9: Opcodes 0x0C, 0x0D and 0x0E zero-extend the immediate and AND, OR or XOR it with rs.
- R10: Opcode 0x0F places the immediate in bits 31:16 of `result` and clears bits 15:0.
- R11: Any opcode/function pair not listed above drives `wr_en` low, `ovf_trap` low, `rsvd_instr` high and `result` to zero. A recognised pair always drives `rsvd_instr` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First register operand (rs); supplies the amount for variable shifts |
| op_b | input | 32 | Second register operand (rt); the value that shifts operate on |
| shamt | input | 5 | Constant shift amount field |
| opcode | input | 6 | Primary operation code |
| funct | input | 6 | Function code, used when opcode is 0x00 |
| imm | input | 16 | Immediate constant field |
| result | output | 32 | Value for the destination register |
| wr_en | output | 1 | Destination register write-enable |
| ovf_trap | output | 1 | Signed overflow exception from a trapping add or subtract |
| rsvd_instr | output | 1 | Opcode/function pair is not recognised |

## Verification
Every encoding is driven with operands chosen so that a wrong choice shows up in the result. The logic operations use mixed-pattern words, so swapping any two of them changes the output. The compare cases use 1 against all-ones, which separates signed from unsigned. The immediate cases use 0xFFFF or 0x8000, so that sign extension and zero extension give different answers. Overflow is tested at both signed limits and also just inside them, on both the trapping and the plain variants, to confirm that only the trapping forms flag and withhold the write. A sweep over every shift amount applies a value with both end bits set, so the fill bit and the direction can be told apart. The variable-shift sweep sets the upper bits of the amount operand to show that they are ignored.

// File: rtl/risc_exec_pkg.sv
package risc_exec_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    SEL_ADD,
    SEL_SUB,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOR,
    SEL_SLT,
    SEL_SLTU,
    SEL_SHL,
    SEL_SHR,
    SEL_SAR,
    SEL_LUI
  } alu_sel_e;

  typedef struct packed {
    alu_sel_e sel;       // datapath function
    logic     src_imm;   // second operand is the widened immediate
    logic     imm_zext;  // widen immediate with zeros instead of sign
    logic     amt_var;   // shift amount from op_a instead of shamt
    logic     trap_ovf;  // signed overflow raises a trap
    logic     legal;     // encoding recognised
  } exec_ctrl_t;

endpackage

// File: rtl/risc_exec_decode.sv
module risc_exec_decode
  import risc_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output exec_ctrl_t       ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.sel      = SEL_ADD;
    ctrl.legal    = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_SLL:  ctrl.sel = SEL_SHL;
          FN_SRL:  ctrl.sel = SEL_SHR;
          FN_SRA:  ctrl.sel = SEL_SAR;
          FN_SLLV: begin ctrl.sel = SEL_SHL; ctrl.amt_var = 1'b1; end
          FN_SRLV: begin ctrl.sel = SEL_SHR; ctrl.amt_var = 1'b1; end
          FN_SRAV: begin ctrl.sel = SEL_SAR; ctrl.amt_var = 1'b1; end
          FN_ADD:  begin ctrl.sel = SEL_ADD; ctrl.trap_ovf = 1'b1; end
          FN_ADDU: ctrl.sel = SEL_ADD;
          FN_SUB:  begin ctrl.sel = SEL_SUB; ctrl.trap_ovf = 1'b1; end
          FN_SUBU: ctrl.sel = SEL_SUB;
          FN_AND:  ctrl.sel = SEL_AND;
          FN_OR:   ctrl.sel = SEL_OR;
          FN_XOR:  ctrl.sel = SEL_XOR;
          FN_NOR:  ctrl.sel = SEL_NOR;
          FN_SLT:  ctrl.sel = SEL_SLT;
          FN_SLTU: ctrl.sel = SEL_SLTU;
          default: ctrl.legal = 1'b0;
        endcase
      end
      OPC_ADDI:  begin ctrl.sel = SEL_ADD;  ctrl.src_imm = 1'b1; ctrl.trap_ovf = 1'b1; end
      OPC_ADDIU: begin ctrl.sel = SEL_ADD;  ctrl.src_imm = 1'b1; end
      OPC_SLTI:  begin ctrl.sel = SEL_SLT;  ctrl.src_imm = 1'b1; end
      OPC_SLTIU: begin ctrl.sel = SEL_SLTU; ctrl.src_imm = 1'b1; end
      OPC_ANDI:  begin ctrl.sel = SEL_AND;  ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      OPC_ORI:   begin ctrl.sel = SEL_OR;   ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      OPC_XORI:  begin ctrl.sel = SEL_XOR;  ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      OPC_LUI:   ctrl.sel = SEL_LUI;
      default:   ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/risc_exec_addsub.sv
module risc_exec_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = b ^ {W{do_sub}};
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
    sum   = wide[W-1:0];
    if (do_sub) begin
      ovf = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
    end else begin
      ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
    // Only meaningful when do_sub is high
    lt_u = ~wide[W];
    lt_s = sum[MSB] ^ ovf;
  end

endmodule

// File: rtl/risc_exec_shifter.sv
module risc_exec_shifter #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          to_left,
  input  logic          arith,
  output logic [W-1:0]  dout
);

  logic [W-1:0] oriented;
  logic [W-1:0] stage [0:AW];
  logic         fill;

  assign fill = arith & ~to_left & din[W-1];

  // Left shifts reuse the right-shift network on a bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_in_rev
    assign oriented[i] = to_left ? din[W-1-i] : din[i];
  end

  assign stage[0] = oriented;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
  end

  for (genvar i = 0; i < W; i++) begin : g_out_rev
    assign dout[i] = to_left ? stage[AW][W-1-i] : stage[AW][i];
  end

endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
  import risc_exec_pkg::*;
#(
  parameter  int XLEN    = 32,
  parameter  int IMM_W   = 16,
  localparam int SHAMT_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]    op_a,
  input  logic [XLEN-1:0]    op_b,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FN_W-1:0]    funct,
  input  logic [IMM_W-1:0]   imm,
  output logic [XLEN-1:0]    result,
  output logic               wr_en,
  output logic               ovf_trap,
  output logic               rsvd_instr
);

  localparam int EXT_W = XLEN - IMM_W;

  exec_ctrl_t         ctrl;
  logic [XLEN-1:0]    imm_wide;
  logic [XLEN-1:0]    src_b;
  logic [XLEN-1:0]    sum;
  logic               ovf_raw;
  logic               lt_s;
  logic               lt_u;
  logic               do_sub;
  logic [SHAMT_W-1:0] sh_amt;
  logic [XLEN-1:0]    sh_out;
  logic [XLEN-1:0]    func_out;

  risc_exec_decode u_decode (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  always_comb begin
    if (ctrl.imm_zext) begin
      imm_wide = {{EXT_W{1'b0}}, imm};
    end else begin
      imm_wide = {{EXT_W{imm[IMM_W-1]}}, imm};
    end
    src_b  = ctrl.src_imm ? imm_wide : op_b;
    do_sub = (ctrl.sel == SEL_SUB) || (ctrl.sel == SEL_SLT) || (ctrl.sel == SEL_SLTU);
    sh_amt = ctrl.amt_var ? op_a[SHAMT_W-1:0] : shamt;
  end

  risc_exec_addsub #(.W(XLEN)) u_addsub (
    .a      (op_a),
    .b      (src_b),
    .do_sub (do_sub),
    .sum    (sum),
    .ovf    (ovf_raw),
    .lt_s   (lt_s),
    .lt_u   (lt_u)
  );

  risc_exec_shifter #(.W(XLEN), .AW(SHAMT_W)) u_shifter (
    .din     (op_b),
    .amt     (sh_amt),
    .to_left (ctrl.sel == SEL_SHL),
    .arith   (ctrl.sel == SEL_SAR),
    .dout    (sh_out)
  );

  always_comb begin
    unique case (ctrl.sel)
      SEL_ADD,
      SEL_SUB:  func_out = sum;
      SEL_AND:  func_out = op_a & src_b;
      SEL_OR:   func_out = op_a | src_b;
      SEL_XOR:  func_out = op_a ^ src_b;
      SEL_NOR:  func_out = ~(op_a | src_b);
      SEL_SLT:  func_out = {{(XLEN-1){1'b0}}, lt_s};
      SEL_SLTU: func_out = {{(XLEN-1){1'b0}}, lt_u};
      SEL_SHL,
      SEL_SHR,
      SEL_SAR:  func_out = sh_out;
      SEL_LUI:  func_out = {imm, {EXT_W{1'b0}}};
      default:  func_out = '0;
    endcase
  end

  always_comb begin
    result     = ctrl.legal ? func_out : '0;
    ovf_trap   = ctrl.legal & ctrl.trap_ovf & ovf_raw;
    wr_en      = ctrl.legal & ~ovf_trap;
    rsvd_instr = ~ctrl.legal;
  end

endmodule

// File: rtl/risc_exec_chk.sv
module risc_exec_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input logic [XLEN-1:0]  op_a,
  input logic [XLEN-1:0]  op_b,
  input logic [5:0]       opcode,
  input logic [5:0]       funct,
  input logic [IMM_W-1:0] imm,
  input logic [XLEN-1:0]  result,
  input logic             wr_en,
  input logic             ovf_trap,
  input logic             rsvd_instr
);

  localparam int M = XLEN - 1;

  logic is_cmp;
  logic trap_kind;
  logic add_rr;

  always_comb begin
    is_cmp    = (opcode == 6'h0A) || (opcode == 6'h0B) ||
                ((opcode == 6'h00) && ((funct == 6'h2A) || (funct == 6'h2B)));
    trap_kind = (opcode == 6'h08) ||
                ((opcode == 6'h00) && ((funct == 6'h20) || (funct == 6'h22)));
    add_rr    = (opcode == 6'h00) && (funct == 6'h20);

    if (ovf_trap) begin
      AST_TRAP_BLOCKS_WRITE: assert (!wr_en)
        else $error("trap with write enabled"); // R5
      AST_TRAP_SOURCE: assert (trap_kind)
        else $error("trap from non-trapping op"); // R6
    end
    if (add_rr) begin
      AST_ADD_OVF_RULE: assert (ovf_trap == ((op_a[M] == op_b[M]) && (result[M] != op_a[M])))
        else $error("add overflow rule"); // R5
    end
    if (is_cmp && !rsvd_instr) begin
      AST_CMP_BOOLEAN: assert (result[XLEN-1:1] == '0)
        else $error("compare result not 0/1"); // R7
    end
    if ((opcode == 6'h0F) && !rsvd_instr) begin
      AST_UPPER_LOAD: assert ((result[XLEN-IMM_W-1:0] == '0) && (result[XLEN-1 -: IMM_W] == imm))
        else $error("upper load shape"); // R10
    end
    if (rsvd_instr) begin
      AST_RESERVED_QUIET: assert (!wr_en && !ovf_trap && (result == '0))
        else $error("reserved encoding active"); // R11
    end
  end

endmodule

bind risc_exec_unit risc_exec_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) i_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .opcode     (opcode),
  .funct      (funct),
  .imm        (imm),
  .result     (result),
  .wr_en      (wr_en),
  .ovf_trap   (ovf_trap),
  .rsvd_instr (rsvd_instr)
);

// File: tb/test_risc_exec_unit.sv
module test_risc_exec_unit;

  localparam int NV  = 33;
  localparam int VW  = 136;

  logic clk;
  logic rst_n;

  logic [31:0] op_a, op_b, result;
  logic [4:0]  shamt;
  logic [5:0]  opcode, funct;
  logic [15:0] imm;
  logic        wr_en, ovf_trap, rsvd_instr;

  int n_checks;
  int n_errors;
  int cycles;

  // {req, opcode, funct, shamt, imm, op_a, op_b, result, {we, ovf, rsvd}}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1,  6'h00, 6'h20, 5'd0,  16'h1234, 32'h00000005, 32'h00000007, 32'h0000000C, 3'b100}, // R1 add
    {4'd1,  6'h00, 6'h21, 5'd0,  16'h0000, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 3'b100}, // R1 addu wrap
    {4'd1,  6'h00, 6'h22, 5'd0,  16'h0000, 32'h0000000A, 32'h00000003, 32'h00000007, 3'b100}, // R1 sub
    {4'd1,  6'h00, 6'h23, 5'd0,  16'h0000, 32'h00000003, 32'h0000000A, 32'hFFFFFFF9, 3'b100}, // R1 subu
    {4'd2,  6'h00, 6'h24, 5'd0,  16'hFFFF, 32'hABCD1234, 32'hFFFF0000, 32'hABCD0000, 3'b100}, // R2 and
    {4'd2,  6'h00, 6'h25, 5'd0,  16'h0000, 32'hABCD1234, 32'hFFFF0000, 32'hFFFF1234, 3'b100}, // R2 or
    {4'd2,  6'h00, 6'h26, 5'd0,  16'h0000, 32'hABCD1234, 32'hFFFF0000, 32'h54321234, 3'b100}, // R2 xor
    {4'd2,  6'h00, 6'h27, 5'd0,  16'h0000, 32'hABCD1234, 32'hFFFF0000, 32'h0000EDCB, 3'b100}, // R2 nor
    {4'd3,  6'h00, 6'h00, 5'd8,  16'h0000, 32'h00000003, 32'hABCD1234, 32'hCD123400, 3'b100}, // R3 sll
    {4'd3,  6'h00, 6'h03, 5'd4,  16'h0000, 32'h00000000, 32'hABCD1234, 32'hFABCD123, 3'b100}, // R3 sra
    {4'd3,  6'h00, 6'h02, 5'd4,  16'h0000, 32'h00000000, 32'hABCD1234, 32'h0ABCD123, 3'b100}, // R3 srl
    {4'd4,  6'h00, 6'h06, 5'd3,  16'h0000, 32'h00000010, 32'hABCD1234, 32'h0000ABCD, 3'b100}, // R4 srlv
    {4'd4,  6'h00, 6'h04, 5'd0,  16'h0000, 32'h00000024, 32'h0000000F, 32'h000000F0, 3'b100}, // R4 sllv
    {4'd4,  6'h00, 6'h07, 5'd0,  16'h0000, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF, 3'b100}, // R4 srav
    {4'd5,  6'h00, 6'h20, 5'd0,  16'h0000, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b010}, // R5 add ovf
    {4'd5,  6'h00, 6'h22, 5'd0,  16'h0000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 3'b010}, // R5 sub ovf
    {4'd5,  6'h00, 6'h22, 5'd0,  16'h0000, 32'h80000000, 32'h80000000, 32'h00000000, 3'b100}, // R5 sub no ovf
    {4'd6,  6'h00, 6'h21, 5'd0,  16'h0000, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b100}, // R6 addu
    {4'd6,  6'h00, 6'h23, 5'd0,  16'h0000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 3'b100}, // R6 subu
    {4'd7,  6'h00, 6'h2A, 5'd0,  16'h0000, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 3'b100}, // R7 slt
    {4'd7,  6'h00, 6'h2B, 5'd0,  16'h0000, 32'h00000001, 32'hFFFFFFFF, 32'h00000001, 3'b100}, // R7 sltu
    {4'd8,  6'h08, 6'h00, 5'd0,  16'hFFFF, 32'h0000000A, 32'h12345678, 32'h00000009, 3'b100}, // R8 addi
    {4'd5,  6'h08, 6'h3F, 5'd0,  16'hFFFF, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 3'b010}, // R5 addi ovf
    {4'd6,  6'h09, 6'h00, 5'd0,  16'hFFFF, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 3'b100}, // R6 addiu
    {4'd8,  6'h0A, 6'h00, 5'd0,  16'hFFFF, 32'hFFFFFFFE, 32'h00000000, 32'h00000001, 3'b100}, // R8 slti
    {4'd8,  6'h0B, 6'h00, 5'd0,  16'hFFFF, 32'h00000005, 32'h00000000, 32'h00000001, 3'b100}, // R8 sltiu
    {4'd9,  6'h0C, 6'h00, 5'd0,  16'hF0F0, 32'hABCD1234, 32'hFFFFFFFF, 32'h00001030, 3'b100}, // R9 andi
    {4'd9,  6'h0D, 6'h00, 5'd0,  16'h8000, 32'hABCD1234, 32'h00000000, 32'hABCD9234, 3'b100}, // R9 ori
    {4'd9,  6'h0E, 6'h00, 5'd0,  16'hFFFF, 32'hFFFF0000, 32'h00000000, 32'hFFFFFFFF, 3'b100}, // R9 xori
    {4'd10, 6'h0F, 6'h00, 5'd0,  16'hAC51, 32'h12345678, 32'h9ABCDEF0, 32'hAC510000, 3'b100}, // R10 lui
    {4'd11, 6'h00, 6'h01, 5'd0,  16'h0000, 32'h00000005, 32'h00000007, 32'h00000000, 3'b001}, // R11 bad funct
    {4'd11, 6'h3F, 6'h20, 5'd0,  16'h0001, 32'h00000005, 32'h00000007, 32'h00000000, 3'b001}, // R11 bad opcode
    {4'd11, 6'h00, 6'h05, 5'd0,  16'h0000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 3'b001}  // R11 gap funct
  };

  risc_exec_unit i_risc_exec_unit (
    .op_a       (op_a),
    .op_b       (op_b),
    .shamt      (shamt),
    .opcode     (opcode),
    .funct      (funct),
    .imm        (imm),
    .result     (result),
    .wr_en      (wr_en),
    .ovf_trap   (ovf_trap),
    .rsvd_instr (rsvd_instr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic apply(input logic [5:0] opc, input logic [5:0] fn, input logic [4:0] sa,
                       input logic [15:0] im, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opcode = opc; funct = fn; shamt = sa; imm = im; op_a = a; op_b = b;
    #2;
  endtask

  task automatic check(input int req, input logic [31:0] exp_res, input logic [2:0] exp_flags);
    n_checks++;
    if (result !== exp_res || {wr_en, ovf_trap, rsvd_instr} !== exp_flags) begin
      n_errors++;
      $display("FAIL R%0d opc=%h fn=%h: result=%h flags=%b expected result=%h flags=%b",
               req, opcode, funct, result, {wr_en, ovf_trap, rsvd_instr}, exp_res, exp_flags);
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    rst_n  = 1'b0;
    opcode = '0; funct = '0; shamt = '0; imm = '0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle encoding (shift-left of zero by zero): zero result, write enabled, R3
    apply(6'h00, 6'h00, 5'd0, 16'h0, 32'h0, 32'h0);
    check(3, 32'h0, 3'b100);

    foreach (VEC[i]) begin
      apply(VEC[i][131:126], VEC[i][125:120], VEC[i][119:115], VEC[i][114:99],
            VEC[i][98:67], VEC[i][66:35]);
      check(int'(VEC[i][135:132]), VEC[i][34:3], VEC[i][2:0]);
    end

    // R3 sweep of constant shift amounts, expected from language operators
    for (int k = 0; k < 32; k++) begin
      apply(6'h00, 6'h00, 5'(k), 16'h0, 32'h0, 32'h80000001);
      check(3, 32'h80000001 << k, 3'b100);
      apply(6'h00, 6'h02, 5'(k), 16'h0, 32'h0, 32'h80000001);
      check(3, 32'h80000001 >> k, 3'b100);
      apply(6'h00, 6'h03, 5'(k), 16'h0, 32'h0, 32'h80000001);
      check(3, 32'($signed(32'h80000001) >>> k), 3'b100);
    end

    // R4 variable shifts: upper amount bits set, only low 5 bits apply
    for (int k = 0; k < 32; k++) begin
      apply(6'h00, 6'h04, 5'd31, 16'h0, 32'hFFFFFFE0 | 32'(k), 32'hC0000003);
      check(4, 32'hC0000003 << k, 3'b100);
      apply(6'h00, 6'h07, 5'd0, 16'h0, 32'h5A5A5A40 | 32'(k), 32'hC0000003);
      check(4, 32'($signed(32'hC0000003) >>> k), 3'b100);
    end

    // R5 add overflow at negative limit; R6 addu wraps and still writes
    apply(6'h00, 6'h20, 5'd0, 16'h0, 32'h80000000, 32'hFFFFFFFF);
    check(5, 32'h7FFFFFFF, 3'b010);
    apply(6'h00, 6'h21, 5'd0, 16'h0, 32'h80000000, 32'hFFFFFFFF);
    check(6, 32'h7FFFFFFF, 3'b100);

    // R8 immediate add ignores op_b entirely
    apply(6'h09, 6'h00, 5'd0, 16'h0010, 32'h00000001, 32'hFFFFFFFF);
    check(8, 32'h00000011, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule